// File: doc/BRIEF.md
# Capture Delay Window Calibrator

This sequencer finds a safe sampling point for a data converter's capture path. After a start pulse it steps a programmable input-delay setting upward from tap zero. At each tap it loads the setting with a one-cycle strobe and runs two pattern tests: first with a ramp requested on the I lane and all-ones on the Q lane, then with the roles swapped. For each test it re-arms the external pattern checker, waits a dwell period, and samples the checker's lock flag and error count. The tap passes only when both tests lock with no errors.

Passing taps are gathered into a window. A window that closes on a failing tap ends the sweep if its span is wide enough; a narrower one is thrown away and the sweep goes on. If a sweep ends without an acceptable window, the block clears its window, waits a long settling period and sweeps again, up to a sweep limit. On success it selects the window midpoint, loads it with a final strobe and raises done. On failure it reports whether no window at all or only a narrow one was found. When finished it returns both lanes to normal data and disables the checker. The delay line, the converter's pattern generator and the pattern checker are outside the block.

Top module: `capdly_window_cal`

## Requirements
- R1: After start, taps are loaded in ascending order from 0, each with `dly_ld` high for exactly one cycle while `dly_val` carries the tap; every sweep restarts at tap 0.
- R2: For each tap the block runs the I test then the Q test. Pattern codes: 0 normal, 1 ramp, 2 all-ones. The I test requests `pat_i`=1, `pat_q`=2; the Q test requests `pat_i`=2, `pat_q`=1. Before each test `chk_en` is low for at least one cycle, then high for exactly `DWELL_CYC` cycles; the strobe-to-strobe period of a tap is 2*`DWELL_CYC`+4 cycles.
- R3: A tap passes only if both tests report lock and zero errors; a missing lock adds `PENALTY` to the tap's error sum, and an error on only one lane fails the tap.
- R4: The first passing tap opens the window (start = stop = tap) and each later passing tap moves stop. A failing tap after an open window with stop minus start of at least `MIN_WIN` ends the sweep at once; no further tap is loaded.
- R5: A window that closes with stop minus start below `MIN_WIN` is discarded and the sweep continues with the next tap.
- R6: A sweep that ends without an acceptable window (none, or one still open at the last tap with a span below `MIN_WIN`) is followed by a wait of at least `SETTLE_CYC` cycles and a new sweep with a cleared window, until `MAX_SWEEPS` sweeps have been made. A window still open at the last tap with enough span is accepted.
- R7: `fail_code` reads 0 on success, 1 when the final sweep found no window, 2 when it found only a window narrower than `MIN_WIN`.
- R8: On success `tap_sel` equals floor((start+stop)/2) and that value is loaded with one final strobe before done; on failure `tap_sel` is 0 and no final strobe is issued.
- R9: When finished, `done` is high and held until the next start, `busy` is low, `chk_en` is low, both pattern codes are 0, and `sweeps_used` gives the number of sweeps made.
- R10: After reset `busy`, `done`, `dly_ld` and `chk_en` are low and both pattern codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when not busy |
| dly_val | output | TAP_W | Delay tap value presented to the delay line |
| dly_ld | output | 1 | One-cycle load strobe for `dly_val` |
| pat_i | output | 2 | Requested I-lane pattern (0 normal, 1 ramp, 2 ones) |
| pat_q | output | 2 | Requested Q-lane pattern (0 normal, 1 ramp, 2 ones) |
| chk_en | output | 1 | Pattern checker enable |
| chk_i_lock | input | 1 | I-lane checker locked |
| chk_i_err | input | ERR_W | I-lane checker error count |
| chk_q_lock | input | 1 | Q-lane checker locked |
| chk_q_err | input | ERR_W | Q-lane checker error count |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished, held until next start |
| fail_code | output | 2 | 0 success, 1 no window, 2 window too narrow |
| tap_sel | output | TAP_W | Selected capture tap |
| sweeps_used | output | SW_W | Number of sweeps made |

## Verification
The bench keeps the 32-tap, 5-bit sweep, the minimum span of 4 and the two-sweep limit, but shortens the dwell to 4 cycles and the settling wait to 40, so a full two-sweep run with a retry completes in under a thousand cycles. With those values the strobe-to-strobe period is an exact 12 cycles, which makes the settling gap clearly separable from a normal tap step and lets every failure path, the retry and the span boundary at exactly 4 be reached within one short run.

// File: rtl/capdly_pkg.sv
package capdly_pkg;

   typedef enum logic [1:0] {
      PAT_NORMAL = 2'd0,
      PAT_RAMP   = 2'd1,
      PAT_ONES   = 2'd2
   } pat_e;

   typedef enum logic [1:0] {
      RES_OK     = 2'd0,
      RES_NO_WIN = 2'd1,
      RES_NARROW = 2'd2
   } res_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_ARM,
      S_DWELL,
      S_EVAL,
      S_SETTLE,
      S_FINAL,
      S_DONE
   } cal_st_e;

endpackage

// File: rtl/capdly_timer.sv
module capdly_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/capdly_err_acc.sv
module capdly_err_acc #(
   parameter int ERR_W   = 16,
   parameter int ACC_W   = 18,
   parameter int PENALTY = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             add,
   input  logic             lock,
   input  logic [ERR_W-1:0] err,
   output logic             acc_zero
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] term;

   assign term = lock ? ACC_W'(err) : ACC_W'(PENALTY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else if (add)   acc_q <= acc_q + term;
   end

   assign acc_zero = (acc_q == '0);
endmodule

// File: rtl/capdly_window.sv
module capdly_window #(
   parameter int TAP_W   = 5,
   parameter int MIN_WIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             eval,
   input  logic             pass,
   input  logic [TAP_W-1:0] tap,
   output logic             nxt_vld,
   output logic [TAP_W-1:0] nxt_lo,
   output logic [TAP_W-1:0] nxt_hi,
   output logic             nxt_wide,
   output logic             close_wide
);
   logic             vld_q;
   logic [TAP_W-1:0] lo_q, hi_q;
   logic             wide_q;

   assign wide_q = ({1'b0, hi_q} - {1'b0, lo_q}) >= (TAP_W+1)'(MIN_WIN);

   always_comb begin
      nxt_vld = vld_q;
      nxt_lo  = lo_q;
      nxt_hi  = hi_q;
      if (eval) begin
         if (pass) begin
            if (!vld_q) begin
               nxt_vld = 1'b1;
               nxt_lo  = tap;
            end
            nxt_hi = tap;
         end else if (vld_q && !wide_q) begin
            nxt_vld = 1'b0;
         end
      end
   end

   assign nxt_wide   = nxt_vld && (({1'b0, nxt_hi} - {1'b0, nxt_lo}) >= (TAP_W+1)'(MIN_WIN));
   assign close_wide = eval && !pass && vld_q && wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (clear) begin
         vld_q <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (eval) begin
         vld_q <= nxt_vld;
         lo_q  <= nxt_lo;
         hi_q  <= nxt_hi;
      end
   end
endmodule

// File: rtl/capdly_window_cal.sv
module capdly_window_cal #(
   parameter int TAP_W      = 5,
   parameter int NUM_TAPS   = 32,
   parameter int MIN_WIN    = 4,
   parameter int MAX_SWEEPS = 2,
   parameter int ERR_W      = 16,
   parameter int PENALTY    = 100,
   parameter int DWELL_CYC  = 2_000_000,
   parameter int SETTLE_CYC = 400_000_000,
   localparam int SW_W      = $clog2(MAX_SWEEPS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic [TAP_W-1:0] dly_val,
   output logic             dly_ld,
   output logic [1:0]       pat_i,
   output logic [1:0]       pat_q,
   output logic             chk_en,
   input  logic             chk_i_lock,
   input  logic [ERR_W-1:0] chk_i_err,
   input  logic             chk_q_lock,
   input  logic [ERR_W-1:0] chk_q_err,
   output logic             busy,
   output logic             done,
   output logic [1:0]       fail_code,
   output logic [TAP_W-1:0] tap_sel,
   output logic [SW_W-1:0]  sweeps_used
);
   import capdly_pkg::*;

   localparam int MAX_CYC = (DWELL_CYC > SETTLE_CYC) ? DWELL_CYC : SETTLE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam int ACC_W   = ERR_W + 2;

   if (NUM_TAPS < 2 || NUM_TAPS > (1 << TAP_W)) begin : g_bad_taps
      $error("NUM_TAPS must lie in 2 .. 2**TAP_W");
   end
   if (MIN_WIN < 1 || MIN_WIN >= NUM_TAPS) begin : g_bad_win
      $error("MIN_WIN must lie in 1 .. NUM_TAPS-1");
   end
   if (MAX_SWEEPS < 1) begin : g_bad_sweeps
      $error("MAX_SWEEPS must be at least 1");
   end
   if (DWELL_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_cyc
      $error("DWELL_CYC and SETTLE_CYC must be at least 1");
   end
   if (PENALTY < 1 || PENALTY >= (1 << ERR_W)) begin : g_bad_pen
      $error("PENALTY must be nonzero and fit in ERR_W bits");
   end

   cal_st_e          st_q;
   logic [TAP_W-1:0] tap_q;
   logic             chan_q;
   logic [SW_W-1:0]  sweep_q;
   logic [TAP_W-1:0] sel_q;
   logic [1:0]       res_q;

   logic             start_go, tmr_load, tmr_exp, retry_go;
   logic [CNT_W-1:0] tmr_val;
   logic             acc_zero, win_eval, win_clear;
   logic             nxt_vld, nxt_wide, close_wide;
   logic [TAP_W-1:0] nxt_lo, nxt_hi, mid;
   logic             last_tap, end_good, finish_ok, finish_bad;
   logic             in_test;

   assign start_go = start && (st_q == S_IDLE || st_q == S_DONE);
   assign last_tap = (tap_q == TAP_W'(NUM_TAPS - 1));
   assign win_eval = (st_q == S_EVAL);
   assign win_clear = start_go || (st_q == S_SETTLE);

   assign end_good   = last_tap && nxt_wide;
   assign finish_ok  = win_eval && (close_wide || end_good);
   assign finish_bad = win_eval && !finish_ok && last_tap && (sweep_q == SW_W'(MAX_SWEEPS));
   assign retry_go   = win_eval && !finish_ok && last_tap && (sweep_q != SW_W'(MAX_SWEEPS));

   assign mid = TAP_W'(({1'b0, nxt_lo} + {1'b0, nxt_hi}) >> 1);

   assign tmr_load = (st_q == S_ARM) || retry_go;
   assign tmr_val  = (st_q == S_ARM) ? CNT_W'(DWELL_CYC - 1) : CNT_W'(SETTLE_CYC - 1);

   capdly_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   capdly_err_acc #(.ERR_W(ERR_W), .ACC_W(ACC_W), .PENALTY(PENALTY)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (st_q == S_LOAD),
      .add      ((st_q == S_DWELL) && tmr_exp),
      .lock     (chan_q ? chk_q_lock : chk_i_lock),
      .err      (chan_q ? chk_q_err  : chk_i_err),
      .acc_zero (acc_zero)
   );

   capdly_window #(.TAP_W(TAP_W), .MIN_WIN(MIN_WIN)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (win_clear),
      .eval       (win_eval),
      .pass       (acc_zero),
      .tap        (tap_q),
      .nxt_vld    (nxt_vld),
      .nxt_lo     (nxt_lo),
      .nxt_hi     (nxt_hi),
      .nxt_wide   (nxt_wide),
      .close_wide (close_wide)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         tap_q   <= '0;
         chan_q  <= 1'b0;
         sweep_q <= '0;
         sel_q   <= '0;
         res_q   <= RES_OK;
      end else begin
         unique case (st_q)
            S_IDLE, S_DONE: if (start_go) begin
               st_q    <= S_LOAD;
               tap_q   <= '0;
               sweep_q <= SW_W'(1);
               sel_q   <= '0;
               res_q   <= RES_OK;
            end
            S_LOAD: begin
               chan_q <= 1'b0;
               st_q   <= S_ARM;
            end
            S_ARM:  st_q <= S_DWELL;
            S_DWELL: if (tmr_exp) begin
               if (!chan_q) begin
                  chan_q <= 1'b1;
                  st_q   <= S_ARM;
               end else begin
                  st_q <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (finish_ok) begin
                  sel_q <= mid;
                  tap_q <= mid;
                  st_q  <= S_FINAL;
               end else if (finish_bad) begin
                  res_q <= nxt_vld ? RES_NARROW : RES_NO_WIN;
                  st_q  <= S_DONE;
               end else if (retry_go) begin
                  st_q <= S_SETTLE;
               end else begin
                  tap_q <= tap_q + 1'b1;
                  st_q  <= S_LOAD;
               end
            end
            S_SETTLE: if (tmr_exp) begin
               tap_q   <= '0;
               sweep_q <= sweep_q + 1'b1;
               st_q    <= S_LOAD;
            end
            S_FINAL: st_q <= S_DONE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign in_test = (st_q == S_ARM) || (st_q == S_DWELL);

   assign dly_val     = tap_q;
   assign dly_ld      = (st_q == S_LOAD) || (st_q == S_FINAL);
   assign chk_en      = (st_q == S_DWELL);
   assign pat_i       = !in_test ? PAT_NORMAL : (chan_q ? PAT_ONES : PAT_RAMP);
   assign pat_q       = !in_test ? PAT_NORMAL : (chan_q ? PAT_RAMP : PAT_ONES);
   assign busy        = (st_q != S_IDLE) && (st_q != S_DONE);
   assign done        = (st_q == S_DONE);
   assign fail_code   = res_q;
   assign tap_sel     = sel_q;
   assign sweeps_used = sweep_q;
endmodule

// File: rtl/capdly_window_cal_chk.sv
module capdly_window_cal_chk #(
   parameter int TAP_W      = 5,
   parameter int MAX_SWEEPS = 2,
   parameter int SW_W       = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dly_ld,
   input logic [TAP_W-1:0] dly_val,
   input logic [1:0]       pat_i,
   input logic [1:0]       pat_q,
   input logic             chk_en,
   input logic             busy,
   input logic             done,
   input logic [1:0]       fail_code,
   input logic [SW_W-1:0]  sweeps_used
);
   a_r1_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
      dly_ld |=> !dly_ld);

   a_r1_ld_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      dly_ld |-> (busy && !done));

   a_r1_val_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !dly_ld && $past(dly_ld)) |-> $stable(dly_val));

   a_r2_en_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ((pat_i == 2'd1 && pat_q == 2'd2) || (pat_i == 2'd2 && pat_q == 2'd1)));

   a_r2_no_ld_in_test: assert property (@(posedge clk) disable iff (!rst_n)
      dly_ld |-> !chk_en);

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !chk_en && !dly_ld && pat_i == 2'd0 && pat_q == 2'd0));

   a_r9_sweeps_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sweeps_used >= SW_W'(1) && sweeps_used <= SW_W'(MAX_SWEEPS)));

   a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fail_code != 2'd3));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!chk_en && pat_i == 2'd0 && pat_q == 2'd0));
endmodule

bind capdly_window_cal capdly_window_cal_chk #(
   .TAP_W(TAP_W), .MAX_SWEEPS(MAX_SWEEPS), .SW_W(SW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dly_ld(dly_ld), .dly_val(dly_val),
   .pat_i(pat_i), .pat_q(pat_q), .chk_en(chk_en), .busy(busy),
   .done(done), .fail_code(fail_code), .sweeps_used(sweeps_used)
);

// File: tb/capdly_window_cal_tb_top.sv
`timescale 1ns/1ps
module capdly_window_cal_tb_top;
   localparam int TAP_W = 5, NUM_TAPS = 32, MIN_WIN = 4, MAX_SWEEPS = 2;
   localparam int ERR_W = 16, PENALTY = 100, DWELL = 4, SETTLE = 40;
   localparam int SW_W = $clog2(MAX_SWEEPS + 1);
   localparam int TAP_PERIOD = 2 * DWELL + 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [TAP_W-1:0] dly_val, tap_sel;
   logic dly_ld, chk_en, busy, done;
   logic [1:0] pat_i, pat_q, fail_code;
   logic chk_i_lock, chk_q_lock;
   logic [ERR_W-1:0] chk_i_err, chk_q_err;
   logic [SW_W-1:0] sweeps_used;

   always #2.5 clk = ~clk;

   capdly_window_cal #(
      .TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS), .MIN_WIN(MIN_WIN), .MAX_SWEEPS(MAX_SWEEPS),
      .ERR_W(ERR_W), .PENALTY(PENALTY), .DWELL_CYC(DWELL), .SETTLE_CYC(SETTLE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .dly_val(dly_val), .dly_ld(dly_ld),
      .pat_i(pat_i), .pat_q(pat_q), .chk_en(chk_en),
      .chk_i_lock(chk_i_lock), .chk_i_err(chk_i_err),
      .chk_q_lock(chk_q_lock), .chk_q_err(chk_q_err),
      .busy(busy), .done(done), .fail_code(fail_code), .tap_sel(tap_sel),
      .sweeps_used(sweeps_used)
   );

   // Line model: per sweep, pass mask, Q-only-error mask, no-lock mask
   logic [31:0] pass_m [2];
   logic [31:0] qbad_m [2];
   logic [31:0] nolk_m [2];
   logic [TAP_W-1:0] cur_tap = '0;
   logic cur_sw = 1'b0;
   logic i_ok, q_ok, i_lk, q_lk, i_sel, q_sel;

   assign i_ok  = pass_m[cur_sw][cur_tap] | qbad_m[cur_sw][cur_tap];
   assign q_ok  = pass_m[cur_sw][cur_tap];
   assign i_lk  = i_ok | !nolk_m[cur_sw][cur_tap];
   assign q_lk  = q_ok | !nolk_m[cur_sw][cur_tap];
   assign i_sel = chk_en && pat_i == 2'd1 && pat_q == 2'd2;
   assign q_sel = chk_en && pat_i == 2'd2 && pat_q == 2'd1;
   assign chk_i_lock = i_sel & i_lk;
   assign chk_q_lock = q_sel & q_lk;
   assign chk_i_err  = (i_sel && i_lk && !i_ok) ? ERR_W'(3) : '0;
   assign chk_q_err  = (q_sel && q_lk && !q_ok) ? ERR_W'(3) : '0;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, ld_n = 0, zero_n = 0, en_cyc = 0, en_rise = 0;
   int ld_val [128];
   int ld_cyc [128];
   logic en_prev = 1'b0;

   initial forever begin
      @(negedge clk);
      cyc++;
      if (dly_ld) begin
         if (ld_n < 128) begin
            ld_val[ld_n] = int'(dly_val);
            ld_cyc[ld_n] = cyc;
         end
         ld_n++;
         cur_tap = dly_val;
         if (dly_val == '0) begin
            zero_n++;
            cur_sw = (zero_n >= 2);
         end
      end
      if (chk_en) en_cyc++;
      if (chk_en && !en_prev) en_rise++;
      en_prev = chk_en;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cal(input logic [31:0] p0, input logic [31:0] q0, input logic [31:0] n0,
                          input logic [31:0] p1, input logic [31:0] q1, input logic [31:0] n1);
      int t;
      pass_m[0] = p0; qbad_m[0] = q0; nolk_m[0] = n0;
      pass_m[1] = p1; qbad_m[1] = q1; nolk_m[1] = n1;
      @(negedge clk);
      ld_n = 0; zero_n = 0; en_cyc = 0; en_rise = 0; cur_sw = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(busy && !done, "R9 busy while running", int'(busy), 1);
      t = 0;
      while (!done && t < 5000) begin
         @(negedge clk);
         t++;
      end
      check(done, "R9 watchdog: done not reached", int'(done), 1);
   endtask

   // sweep0 taps n0, sweep1 taps n1 (0 = none), final strobe value fin (-1 = none)
   task automatic check_seq(input string req, input int n0, input int n1, input int fin);
      int exp_n = n0 + n1 + (fin >= 0 ? 1 : 0);
      bit ok = (ld_n == exp_n);
      check(ok, {req, " strobe count"}, ld_n, exp_n);
      for (int k = 0; k < n0 && k < ld_n; k++) if (ld_val[k] != k) ok = 0;
      for (int k = 0; k < n1 && n0 + k < ld_n; k++) if (ld_val[n0 + k] != k) ok = 0;
      if (fin >= 0 && exp_n <= ld_n && ld_val[exp_n - 1] != fin) ok = 0;
      check(ok, {req, " R1 tap order"}, (ld_n > 0 ? ld_val[ld_n - 1] : -1), fin);
   endtask

   task automatic check_end(input string req, input int code, input int sel, input int sw);
      check(int'(fail_code) == code, {req, " R7 fail_code"}, int'(fail_code), code);
      check(int'(tap_sel) == sel, {req, " R8 tap_sel"}, int'(tap_sel), sel);
      check(int'(sweeps_used) == sw, {req, " R9 sweeps_used"}, int'(sweeps_used), sw);
      check(!busy && !chk_en && pat_i == 2'd0 && pat_q == 2'd0, {req, " R9 quiet at end"},
            int'({busy, chk_en, pat_i, pat_q}), 0);
   endtask

   task automatic t_reset;
      check(!busy && !done && !dly_ld && !chk_en, "R10 reset flags",
            int'({busy, done, dly_ld, chk_en}), 0);
      check(pat_i == 2'd0 && pat_q == 2'd0, "R10 reset pattern", int'({pat_i, pat_q}), 0);
   endtask

   // R3 R4: window 5..12 closes at tap 13 where only Q errors
   task automatic t_early_stop;
      run_cal(32'h0000_1FE0, 32'h0000_2000, 32'h0, 32'h0, 32'h0, 32'h0);
      check_seq("R4 early stop", 14, 0, 8);
      check_end("R4 early stop", 0, 8, 1);
      check(en_rise == 28, "R2 checker arm count", en_rise, 28);
      check(en_cyc == 28 * DWELL, "R2 dwell cycles", en_cyc, 28 * DWELL);
      check(ld_cyc[1] - ld_cyc[0] == TAP_PERIOD, "R2 tap period", ld_cyc[1] - ld_cyc[0], TAP_PERIOD);
      repeat (5) @(negedge clk);
      check(done && int'(tap_sel) == 8, "R9 done held", int'(done), 1);
   endtask

   // R5: narrow 2..4 discarded, then 10..20 taken at tap 21
   task automatic t_discard;
      run_cal(32'h001F_FC1C, 32'h0, 32'hFFE0_03E3, 32'h0, 32'h0, 32'h0);
      check_seq("R5 discard", 22, 0, 15);
      check_end("R5 discard", 0, 15, 1);
   endtask

   // R4 R5 boundary: span 3 (3..6) dropped, span 4 (20..24) accepted
   task automatic t_boundary;
      run_cal(32'h01F0_0078, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
      check_seq("R4 span boundary", 26, 0, 22);
      check_end("R4 span boundary", 0, 22, 1);
   endtask

   // R3 R6: sweep 0 never locks, sweep 1 passes 16..31 open at end
   task automatic t_retry;
      run_cal(32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0, 32'h0000_FFFF);
      check_seq("R6 retry", 32, 32, 23);
      check_end("R6 retry", 0, 23, 2);
      if (ld_n >= 33)
         check(ld_cyc[32] - ld_cyc[31] >= SETTLE + TAP_PERIOD, "R6 settle gap",
               ld_cyc[32] - ld_cyc[31], SETTLE + TAP_PERIOD);
   endtask

   // R7: no window in either sweep
   task automatic t_no_window;
      run_cal(32'h0, 32'h0, 32'h5555_5555, 32'h0, 32'h0, 32'hAAAA_AAAA);
      check_seq("R7 no window", 32, 32, -1);
      check_end("R7 no window", 1, 0, 2);
   endtask

   // R6 R7: narrow window 29..31 open at the end of both sweeps
   task automatic t_narrow;
      run_cal(32'hE000_0000, 32'h0, 32'h0, 32'hE000_0000, 32'h0, 32'h0);
      check_seq("R7 narrow", 32, 32, -1);
      check_end("R7 narrow", 2, 0, 2);
   endtask

   initial begin
      pass_m[0] = '0; qbad_m[0] = '0; nolk_m[0] = '0;
      pass_m[1] = '0; qbad_m[1] = '0; nolk_m[1] = '0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_early_stop();
      t_discard();
      t_boundary();
      t_retry();
      t_no_window();
      t_narrow();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule